// File: doc/BRIEF.md
# Variable-Modulus SPI Slave with Frame Check

This block is the serial front end of a multi-channel driver. It receives 16-bit command words from an SPI master in clock mode where the slave output changes on the rising serial clock and the input is taken on the falling serial clock. At the same time it returns a 16-bit status word, most significant bit first. The serial clock, chip select and data input are brought into the system clock domain through two-stage synchronisers. Every serial event is handled as an edge that is detected in that domain.

The frame length is checked so that the block can share a daisy chain with 8-bit and 16-bit neighbours. The first 16 serial clocks are counted modulo 16 and any later clocks modulo 8. Only a frame of 16 + 8n clocks is accepted, and it writes its last 16 received bits to the command register. Any other frame is dropped. After its own status word, the output repeats the bits received on the input, which gives the shift-through a chain needs. Between chip-select fall and the first rising serial clock, the output shows a pseudo-bit: the latched thermal-shutdown flag ORed with the data input. A flag raised anywhere in the chain therefore ripples to the master.

A control FSM steps through four states. In IDLE the chip select is high. PRE runs from chip-select fall to the first rising clock. WORD covers the first 16 clocks and EXT covers each further group of 8. The named transitions are:
- IDLE to PRE on chip-select fall, which loads the status word.
- PRE to WORD on the first rising clock.
- WORD to EXT on the 16th rising clock.
- any state to IDLE on chip-select rise, which commits the command only when leaving EXT with the modulo-8 count at zero.

Top module: `vmspi_slave`

## Requirements
- R1: While reset is asserted and after its release, the command register reads 0, the commit and reset strobes are low, and the output enable is low.
- R2: While chip select is high, the output enable `sdo_oe_o` is low.
- R3: From chip-select fall until the first rising serial clock, the output equals `therm_latch_i` ORed with `sdi_i`, with the output enable high.
- R4: From the first rising serial clock on, the output presents the status word captured at chip-select fall, bit 15 first, one bit per rising clock. Changes on `stat_word_i` during the frame have no effect.
- R5: After the 16 status bits, each rising clock presents the next bit received on the input, in arrival order.
- R6: Input bits are taken on falling serial clocks, first bit as the most significant; the command is the last 16 bits received.
- R7: A frame of 16, 24, 32 or any 16+8n rising clocks is accepted, and the command register takes the last 16 received bits.
- R8: A frame of any other length, including 0, 8, 15, 17 and 20 clocks, leaves the command register unchanged and raises no strobe.
- R9: `cmd_commit_o` is a single-cycle pulse, and `cmd_o` takes its new value in the same cycle. Both are due on the third system clock edge after chip-select rises.
- R10: When an accepted command has bit 15 set, `srr_pulse_o` pulses together with the commit. Bit 14 of `cmd_o` then names the channel group the reset applies to: 0 means channels 1 to 6 and 1 means channels 7 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on or enable low) |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in |
| therm_latch_i | input | 1 | Latched thermal-shutdown flag |
| stat_word_i | input | 16 | Status word offered for the next frame |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the tri-state serial output |
| cmd_o | output | 16 | Command register |
| cmd_commit_o | output | 1 | One-cycle strobe on an accepted frame |
| srr_pulse_o | output | 1 | One-cycle status-reset strobe |

## Verification
Every serial event reaches the logic three system clock edges after the pin moves: two synchroniser stages and one state register. A serial output bit is therefore due three edges after its rising serial clock. The bench waits eight system clocks after each rising clock and samples at a falling system clock. A commit and its command are due on exactly the third edge after chip-select rises. One frame checks the cycles before that edge and the edge itself. Expected commands are queued by the frame driver only for lengths of 16+8n. A monitor compares every strobe it sees against the head of that queue, and it counts any strobe with an empty queue as a failure.

// File: rtl/vmspi_pkg.sv
package vmspi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_WORD = 2'd2,
        ST_EXT  = 2'd3
    } vmspi_state_e;
endpackage

// File: rtl/vmspi_sync.sv
module vmspi_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign q_o    = stage_q[STAGES-1];
    assign rise_o = stage_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/vmspi_lencheck.sv
module vmspi_lencheck #(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic word_step_i,
    input  logic ext_step_i,
    output logic word_last_o,
    output logic ext_aligned_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int MOD_W = (EXT_W > 1) ? $clog2(EXT_W) : 1;

    logic [CNT_W-1:0] word_cnt;
    logic [MOD_W-1:0] ext_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_cnt <= '0;
            ext_cnt  <= '0;
        end else if (clr_i) begin
            word_cnt <= '0;
            ext_cnt  <= '0;
        end else begin
            if (word_step_i) word_cnt <= word_cnt + 1'b1;
            if (ext_step_i) begin
                if (ext_cnt == MOD_W'(EXT_W - 1)) ext_cnt <= '0;
                else                              ext_cnt <= ext_cnt + 1'b1;
            end
        end
    end

    assign word_last_o   = (word_cnt == CNT_W'(WORD_W - 1));
    assign ext_aligned_o = (ext_cnt == '0);
endmodule

// File: rtl/vmspi_shifter.sv
module vmspi_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_val_i,
    input  logic              tx_step_i,
    input  logic              rx_step_i,
    input  logic              sdi_i,
    output logic              tx_msb_o,
    output logic [WORD_W-1:0] rx_word_o
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic              si_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q      <= '0;
            rx_q      <= '0;
            si_hold_q <= 1'b0;
        end else begin
            if (load_i)         tx_q <= load_val_i;
            else if (tx_step_i) tx_q <= {tx_q[WORD_W-2:0], si_hold_q};
            if (rx_step_i) begin
                rx_q      <= {rx_q[WORD_W-2:0], sdi_i};
                si_hold_q <= sdi_i;
            end
        end
    end

    assign tx_msb_o  = tx_q[WORD_W-1];
    assign rx_word_o = rx_q;
endmodule

// File: rtl/vmspi_slave.sv
module vmspi_slave
    import vmspi_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int EXT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    input  logic              therm_latch_i,
    input  logic [WORD_W-1:0] stat_word_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [WORD_W-1:0] cmd_o,
    output logic              cmd_commit_o,
    output logic              srr_pulse_o
);
    localparam int SRR_BIT = WORD_W - 1;
    localparam int PIN_N   = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

    logic [PIN_N-1:0] pin_q, pin_rise, pin_fall;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall, cs_level, sdi_s;

    vmspi_sync #(.W(PIN_N), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({sdi_i, csn_i, sclk_i}),
        .q_o    (pin_q),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign sclk_rise = pin_rise[0];
    assign sclk_fall = pin_fall[0];
    assign cs_rise   = pin_rise[1];
    assign cs_fall   = pin_fall[1];
    assign cs_level  = pin_q[1];
    assign sdi_s     = pin_q[2];

    vmspi_state_e state_q, state_d;
    logic word_last, ext_aligned;
    logic word_step, ext_step, tx_step, rx_step, frame_ok;
    logic tx_msb;
    logic [WORD_W-1:0] rx_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_PRE;
            ST_PRE: begin
                if (cs_rise)        state_d = ST_IDLE;
                else if (sclk_rise) state_d = ST_WORD;
            end
            ST_WORD: begin
                if (cs_rise)                     state_d = ST_IDLE;
                else if (sclk_rise && word_last) state_d = ST_EXT;
            end
            ST_EXT: if (cs_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign word_step = sclk_rise && !cs_rise &&
                       ((state_q == ST_PRE) || ((state_q == ST_WORD) && !word_last));
    assign ext_step  = sclk_rise && !cs_rise && (state_q == ST_EXT);
    assign tx_step   = sclk_rise && !cs_rise &&
                       ((state_q == ST_WORD) || (state_q == ST_EXT));
    assign rx_step   = sclk_fall && !cs_rise && (state_q != ST_IDLE);
    assign frame_ok  = cs_rise && (state_q == ST_EXT) && ext_aligned;

    vmspi_lencheck #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_len (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (cs_fall),
        .word_step_i   (word_step),
        .ext_step_i    (ext_step),
        .word_last_o   (word_last),
        .ext_aligned_o (ext_aligned)
    );

    vmspi_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cs_fall && (state_q == ST_IDLE)),
        .load_val_i (stat_word_i),
        .tx_step_i  (tx_step),
        .rx_step_i  (rx_step),
        .sdi_i      (sdi_s),
        .tx_msb_o   (tx_msb),
        .rx_word_o  (rx_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o        <= '0;
            cmd_commit_o <= 1'b0;
            srr_pulse_o  <= 1'b0;
        end else begin
            cmd_commit_o <= frame_ok;
            srr_pulse_o  <= frame_ok && rx_word[SRR_BIT];
            if (frame_ok) cmd_o <= rx_word;
        end
    end

    assign sdo_oe_o = !cs_level;
    assign sdo_o    = ((state_q == ST_IDLE) || (state_q == ST_PRE)) ?
                      (therm_latch_i | sdi_i) : tx_msb;
endmodule

// File: rtl/vmspi_slave_chk.sv
module vmspi_slave_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_i,
    input logic              sdo_oe_o,
    input logic [WORD_W-1:0] cmd_o,
    input logic              cmd_commit_o,
    input logic              srr_pulse_o
);
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csn_i, 2) && $past(csn_i, 3)) |-> !sdo_oe_o);

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_commit_o |-> $stable(cmd_o));

    assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit_o |=> !cmd_commit_o);

    assert_commit_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit_o |-> $past(csn_i, 3));

    assert_srr_with_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srr_pulse_o |-> (cmd_commit_o && cmd_o[WORD_W-1]));

    assert_srr_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_commit_o && cmd_o[WORD_W-1]) |-> srr_pulse_o);
endmodule

bind vmspi_slave vmspi_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csn_i        (csn_i),
    .sdo_oe_o     (sdo_oe_o),
    .cmd_o        (cmd_o),
    .cmd_commit_o (cmd_commit_o),
    .srr_pulse_o  (srr_pulse_o)
);

// File: tb/tb_vmspi_slave.sv
module tb_vmspi_slave;
    localparam int CLK_P = 10;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_i = 1'b0;
    logic csn_i = 1'b1;
    logic sdi_i = 1'b0;
    logic therm_latch_i = 1'b0;
    logic [15:0] stat_word_i = 16'h0000;
    logic sdo_o, sdo_oe_o, cmd_commit_o, srr_pulse_o;
    logic [15:0] cmd_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    logic [15:0] last_cmd = 16'h0000;
    logic prev_commit = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vmspi_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
        .therm_latch_i(therm_latch_i), .stat_word_i(stat_word_i),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .cmd_o(cmd_o),
        .cmd_commit_o(cmd_commit_o), .srr_pulse_o(srr_pulse_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard on commit strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_commit_o) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected commit", 16'h1, 16'h0);
                end else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    check("R7 command", cmd_o, e);
                    check("R10 srr strobe", {15'b0, srr_pulse_o}, {15'b0, e[15]});
                    last_cmd = e;
                end
                if (prev_commit) check("R9 single pulse", 16'h1, 16'h0);
            end
            prev_commit = cmd_commit_o;
        end
    end

    // driver: one frame, nbits clocks, first bit = bits[nbits-1]
    task automatic frame(input int nbits, input logic [39:0] bits,
                         input logic [15:0] stat, input logic tsd, input bit lat_chk);
        bit valid;
        stat_word_i = stat;
        therm_latch_i = tsd;
        sdi_i = 1'b0;
        wait_clk(2);
        check("R2 oe idle", {15'b0, sdo_oe_o}, 16'h0);
        csn_i = 1'b0;
        wait_clk(5);
        check("R3 pre-bit sdi=0", {15'b0, sdo_oe_o, sdo_o}, {14'b0, 1'b1, tsd});
        sdi_i = 1'b1;
        stat_word_i = ~stat;
        wait_clk(1);
        check("R3 pre-bit sdi=1", {15'b0, sdo_o}, 16'h1);
        for (int i = 0; i < nbits; i++) begin
            sdi_i = bits[nbits-1-i];
            wait_clk(HALF);
            sclk_i = 1'b1;
            wait_clk(HALF);
            if (i < 16) check("R4 status bit", {15'b0, sdo_o}, {15'b0, stat[15-i]});
            else        check("R5 daisy bit", {15'b0, sdo_o}, {15'b0, bits[nbits-1-(i-16)]});
            sclk_i = 1'b0;
            wait_clk(HALF);
        end
        sdi_i = 1'b0;
        valid = (nbits >= 16) && (((nbits - 16) % 8) == 0);
        if (valid) exp_q.push_back(bits[15:0]);
        csn_i = 1'b1;
        if (lat_chk) begin
            wait_clk(2);
            check("R9 no commit before third edge", {15'b0, cmd_commit_o}, 16'h0);
            wait_clk(1);
            check("R9 commit on third edge", {15'b0, cmd_commit_o}, 16'h1);
            check("R9 cmd with commit", cmd_o, bits[15:0]);
            wait_clk(HALF);
        end else begin
            wait_clk(2 * HALF);
        end
        check("R7/R8 queue drained", 16'(exp_q.size()), 16'h0);
        check("R8 cmd state", cmd_o, last_cmd);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        check("R1 cmd in reset", cmd_o, 16'h0);
        check("R1 strobes in reset", {14'b0, cmd_commit_o, srr_pulse_o}, 16'h0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 cmd after reset", cmd_o, 16'h0);
        check("R1 oe after reset", {15'b0, sdo_oe_o}, 16'h0);

        // R6 R7: basic 16-clock frame
        frame(16, 40'h2A5C, 16'hC3A5, 1'b0, 1'b0);
        // R5 R7: 24-clock daisy frame, group bit set
        frame(24, {16'h0, 8'hB7, 16'h4123} >> 0, 16'h5A0F, 1'b0, 1'b0);
        // R7: 32-clock frame
        frame(32, 40'h00_9E3C_1707, 16'h8001, 1'b0, 1'b0);
        // R8: invalid lengths
        frame(0,  40'h0,      16'h1234, 1'b0, 1'b0);
        frame(8,  40'hFF,     16'h1234, 1'b0, 1'b0);
        frame(15, 40'h7ABC,   16'h1234, 1'b0, 1'b0);
        frame(17, 40'h1F00F,  16'h1234, 1'b0, 1'b0);
        frame(20, 40'hABCDE,  16'h1234, 1'b0, 1'b0);
        // R3 with thermal flag, R10 SRR group 0, R9 latency
        frame(16, 40'h8015, 16'hFFFF, 1'b1, 1'b1);
        // R10 SRR group 1
        frame(16, 40'hC0C3, 16'h0000, 1'b0, 1'b0);
        // R7 40-clock frame
        frame(40, 40'hAA_55AA_3C5A, 16'h6996, 1'b0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule